// File: doc/BRIEF.md
# ADC Output Channel Mode Formatter

This block sits between the stereo converter's sample source and the serial transmitter of the converter output stream. It decides which sample each word-clock half-frame carries. It holds the most recent left and right samples and loads two slot registers once per frame. The transmitter then reads the slot for the half-frame it is currently shifting.

In stereo mode the left sample goes to the first slot and the right sample to the second. In monaural mode one chosen channel fills both slots, so the transmitter sends the same word twice per frame. The block does not care which framing or word length the transmitter uses. The same slot contents serve I2S, left-justified and right-justified transmission at any word length up to the sample width.

Mode control comes from an 8-bit control byte, of which three bits are decoded. The decoded mode is captured only at a frame boundary. A frame is therefore never split between two modes or two sample pairs.

Top module: `adc_chmode_fmt`

## Requirements
- R1: While reset is asserted and right after it, `word_o`, `mono_o` and `in_b_o` are all 0, whatever the value of `half_i`.
- R2: With `ctrl_i` bit 7 = 0 (stereo) at a frame boundary, `word_o` carries the left sample while `half_i` = 0 and the right sample while `half_i` = 1, for that frame.
- R3: With `ctrl_i` bit 7 = 1 and bit 6 = 0 at a frame boundary, `word_o` carries the left sample in both halves, and `mono_o` = 1.
- R4: With `ctrl_i` bit 7 = 1 and bit 6 = 1 at a frame boundary, `word_o` carries the right sample in both halves, and `mono_o` = 1.
- R5: `in_b_o` equals `ctrl_i` bit 1 as captured at the most recent frame boundary, so that analog input B can be selected alongside monaural mode.
- R6: Changes of `ctrl_i` between frame boundaries do not affect `word_o`, `mono_o` or `in_b_o` until the next cycle with `frame_start_i` = 1.
- R7: A sample pair accepted (`smp_vld_i` = 1) between frame boundaries does not appear on `word_o` until the next frame boundary. At that boundary the most recently accepted pair is used.
- R8: A sample pair accepted in the same cycle as `frame_start_i` is the pair loaded into the slots at that boundary.
- R9: `ctrl_i` bits other than 7, 6 and 1 have no effect on any output.
- R10: Samples pass bit-exact over the full `DATA_W` width, including all-zero, all-one and MSB-only values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Control byte: bit 7 monaural, bit 6 right-channel pick, bit 1 input B |
| frame_start_i | input | 1 | One-cycle pulse at each frame boundary |
| half_i | input | 1 | Half-frame being transmitted: 0 first (left) slot, 1 second (right) slot |
| smp_vld_i | input | 1 | New sample pair present on `smp_l_i`/`smp_r_i` |
| smp_l_i | input | DATA_W | Left converter sample |
| smp_r_i | input | DATA_W | Right converter sample |
| word_o | output | DATA_W | Sample for the current half-frame |
| mono_o | output | 1 | Monaural mode in force for the current frame |
| in_b_o | output | 1 | Input B selection in force for the current frame |

## Verification
The hardest case to reach is a control byte or a new sample pair that arrives in the middle of a frame. A bench that only pulses `frame_start_i` together with each new stimulus never exercises the hold behaviour. The stimulus therefore places a frame boundary first, then changes `ctrl_i` and presents a fresh sample pair without a boundary, and checks both halves of `word_o` before and after the next boundary. A sweep over all 256 control bytes, with samples that differ in every bit, separates the decoded bits from the ignored ones.

// File: rtl/adc_chmode_pkg.sv
package adc_chmode_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned MONO_BIT = 7;
  localparam int unsigned PICK_BIT = 6;
  localparam int unsigned INB_BIT  = 1;
  localparam int unsigned NUM_SLOT = 2;

  typedef struct packed {
    logic mono;
    logic pick_r;
    logic in_b;
  } chmode_t;

  function automatic chmode_t decode_ctrl(input logic [CTRL_W-1:0] c);
    chmode_t m;
    m.mono   = c[MONO_BIT];
    m.pick_r = c[PICK_BIT];
    m.in_b   = c[INB_BIT];
    return m;
  endfunction
endpackage

// File: rtl/adc_fmt_sample_hold.sv
module adc_fmt_sample_hold #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] l_i,
  input  logic [DATA_W-1:0] r_i,
  output logic [DATA_W-1:0] cand_l_o,
  output logic [DATA_W-1:0] cand_r_o
);
  logic [DATA_W-1:0] hold_l_q, hold_r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (vld_i) begin
      hold_l_q <= l_i;
      hold_r_q <= r_i;
    end
  end

  // same-cycle bypass so a pair landing on the boundary is not lost
  assign cand_l_o = vld_i ? l_i : hold_l_q;
  assign cand_r_o = vld_i ? r_i : hold_r_q;
endmodule

// File: rtl/adc_fmt_mode_reg.sv
module adc_fmt_mode_reg
  import adc_chmode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output chmode_t           mode_d_o,
  output chmode_t           mode_q_o
);
  chmode_t mode_q;

  assign mode_d_o = decode_ctrl(ctrl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= '0;
    else if (load_i) mode_q <= mode_d_o;
  end

  assign mode_q_o = mode_q;

  assert_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_q));
endmodule

// File: rtl/adc_fmt_slot_route.sv
module adc_fmt_slot_route
  import adc_chmode_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  chmode_t           mode_i,
  input  logic [DATA_W-1:0] l_i,
  input  logic [DATA_W-1:0] r_i,
  output logic [NUM_SLOT-1:0][DATA_W-1:0] slot_o
);
  logic [DATA_W-1:0] pick;
  assign pick = mode_i.pick_r ? r_i : l_i;

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    if (s == 0) begin : g_first
      assign slot_o[s] = mode_i.mono ? pick : l_i;
    end else begin : g_second
      assign slot_o[s] = mode_i.mono ? pick : r_i;
    end
  end
endmodule

// File: rtl/adc_chmode_fmt.sv
module adc_chmode_fmt
  import adc_chmode_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        ctrl_i,
  input  logic              frame_start_i,
  input  logic              half_i,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_l_i,
  input  logic [DATA_W-1:0] smp_r_i,
  output logic [DATA_W-1:0] word_o,
  output logic              mono_o,
  output logic              in_b_o
);
  logic [DATA_W-1:0] cand_l, cand_r;
  chmode_t mode_d, mode_q;
  logic [NUM_SLOT-1:0][DATA_W-1:0] slot_d, slot_q;

  adc_fmt_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(smp_vld_i),
    .l_i(smp_l_i), .r_i(smp_r_i),
    .cand_l_o(cand_l), .cand_r_o(cand_r)
  );

  adc_fmt_mode_reg u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(frame_start_i),
    .ctrl_i(ctrl_i), .mode_d_o(mode_d), .mode_q_o(mode_q)
  );

  // route with the incoming mode so slots and mode switch on the same edge
  adc_fmt_slot_route #(.DATA_W(DATA_W)) u_route (
    .mode_i(mode_d), .l_i(cand_l), .r_i(cand_r), .slot_o(slot_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            slot_q <= '0;
    else if (frame_start_i) slot_q <= slot_d;
  end

  assign word_o = slot_q[half_i];
  assign mono_o = mode_q.mono;
  assign in_b_o = mode_q.in_b;

  assert_mono_dup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.mono |-> (slot_q[0] == slot_q[1]));

  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(slot_q));

  assert_stereo_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !ctrl_i[MONO_BIT]) |=>
      (slot_q[0] == $past(cand_l) && slot_q[1] == $past(cand_r)));

  assert_pick_right_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && ctrl_i[MONO_BIT] && ctrl_i[PICK_BIT]) |=>
      (slot_q[0] == $past(cand_r)));
endmodule

// File: tb/adc_chmode_fmt_tb.sv
module adc_chmode_fmt_tb;
  localparam int unsigned W = 8;

  logic clk = 0;
  logic rst_ni = 0;
  logic [7:0] ctrl = 0;
  logic fs = 0, half = 0, vld = 0;
  logic [W-1:0] sl = 0, sr = 0;
  logic [W-1:0] word;
  logic mono, inb;

  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  adc_chmode_fmt #(.DATA_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl), .frame_start_i(fs),
    .half_i(half), .smp_vld_i(vld), .smp_l_i(sl), .smp_r_i(sr),
    .word_o(word), .mono_o(mono), .in_b_o(inb)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_frame(input string req, input logic [7:0] c,
                             input logic [W-1:0] l, input logic [W-1:0] r);
    logic [W-1:0] pick, e0, e1;
    pick = c[6] ? r : l;
    e0 = c[7] ? pick : l;
    e1 = c[7] ? pick : r;
    half = 0; #1 chk(req, word, e0);
    half = 1; #1 chk(req, word, e1);
    chk(req, {{(W-1){1'b0}}, mono}, {{(W-1){1'b0}}, c[7]});
    chk(req, {{(W-1){1'b0}}, inb}, {{(W-1){1'b0}}, c[1]});
  endtask

  // boundary with a same-cycle sample pair (R8)
  task automatic frame(input logic [7:0] c, input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    ctrl = c; sl = l; sr = r; vld = 1; fs = 1;
    @(negedge clk);
    vld = 0; fs = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    half = 0; #3 chk("R1", word, '0);
    half = 1; #1 chk("R1", word, '0);
    chk("R1", {{(W-1){1'b0}}, mono}, '0);
    chk("R1", {{(W-1){1'b0}}, inb}, '0);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1", word, '0);

    // R2 R3 R4 R5 R9 sweep of every control byte
    for (int c = 0; c < 256; c++) begin
      logic [W-1:0] l, r;
      l = W'(c * 37 + 5);
      r = ~l;
      frame(8'(c), l, r);
      if (!c[7])       check_frame("R2", 8'(c), l, r);
      else if (!c[6])  check_frame("R3", 8'(c), l, r);
      else             check_frame("R4", 8'(c), l, r);
      if (c[1]) check_frame("R5", 8'(c), l, r);
      if ((c & 8'h3d) != 0) check_frame("R9", 8'(c), l, r);
    end

    // R8 same-cycle pair vs earlier held pair
    @(negedge clk); sl = 8'h11; sr = 8'h22; vld = 1;
    @(negedge clk); vld = 0;
    frame(8'h00, 8'h33, 8'h44);
    check_frame("R8", 8'h00, 8'h33, 8'h44);

    // R7 mid-frame pair held until boundary, latest pair wins
    @(negedge clk); sl = 8'h55; sr = 8'h66; vld = 1;
    @(negedge clk); sl = 8'h77; sr = 8'h88;
    @(negedge clk); vld = 0; sl = 8'h00; sr = 8'h00;
    check_frame("R7", 8'h00, 8'h33, 8'h44);
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
    check_frame("R7", 8'h00, 8'h77, 8'h88);

    // R6 control change mid-frame ignored until boundary
    @(negedge clk); ctrl = 8'hc2;
    repeat (3) @(negedge clk);
    check_frame("R6", 8'h00, 8'h77, 8'h88);
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
    check_frame("R6", 8'hc2, 8'h77, 8'h88);
    @(negedge clk); ctrl = 8'h00;
    @(negedge clk);
    check_frame("R6", 8'hc2, 8'h77, 8'h88);

    // R10 full-width extremes
    frame(8'h00, '1, '0);
    check_frame("R10", 8'h00, '1, '0);
    frame(8'h00, {1'b1, {(W-1){1'b0}}}, {{(W-1){1'b0}}, 1'b1});
    check_frame("R10", 8'h00, {1'b1, {(W-1){1'b0}}}, {{(W-1){1'b0}}, 1'b1});
    frame(8'h80, '1, '0);
    check_frame("R10", 8'h80, '1, '0);
    frame(8'hc0, '1, '0);
    check_frame("R10", 8'hc0, '1, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule